// File: doc/BRIEF.md
# Banked General Register File

This block stores the general registers of a small 8/16-bit processor. It holds four banks of eight byte registers. Two bank-select bits in the processor status word pick the bank that the register-number port sees. Through that port the core reads and writes one register at a time. A register can be a single byte, a 16-bit pair, the stack pointer, the status word or one of four segment/control bytes. Reads are combinational. Writes take effect on the rising clock edge.

A second port is a 32-byte memory window over every bank, whichever bank is active. Each bank sits in the window in reverse bank order, so bank 0 occupies the top eight bytes. A branch-condition evaluator is built in. It reports whether a selected condition holds, using the zero and carry flags of the status word or a 16-bit operand.

Top module: `banked_gpr_file`

## Requirements
- R1: After reset every register byte of every bank is 0x11, the status word is 0x06, ES is 0x0F, and CS, PMC, MEM and the stack pointer are 0.
- R2: Register codes 1..8 select the byte registers X, A, C, B, E, D, L, H (bank offsets 0..7) of the active bank. A read returns the byte zero-extended to 16 bits, and a write stores the low data byte.
- R3: Codes 9, 10, 11 and 12 select the pairs AX, BC, DE and HL. A read returns high*256+low with A, B, D, H as the high bytes. A write stores data[15:8] into the high register and data[7:0] into the low register.
- R4: Code 13 selects the 16-bit stack pointer. A write stores the value with bit 0 cleared, and a read returns the stored value.
- R5: The output spOddPulse is high for exactly the one cycle after a stack-pointer write whose data bit 0 was 1, and low otherwise.
- R6: The active bank is {PSW[5], PSW[3]}. The status-word bits from bit 7 down are IE, Z, RBS1, AC, RBS0, ISP1, ISP0, CY. A status-word write changes the bank used by register accesses from the next cycle on.
- R7: The window port reads and writes byte i of bank b at window address (3-b)*8+i, whichever bank is active. Window reads are combinational.
- R8: Code 0 and the unused codes 19..31 read as zero. A write to them changes no state and drives noneWrErr high for the next cycle only.
- R9: Codes 14..18 select PSW, CS, ES, PMC and MEM. A read returns the byte zero-extended, and a write stores the low data byte.
- R10: When the register-number port and the window port write the same byte in one cycle, the register-number port's value is stored.
- R11: condTrue follows condCode with this encoding: 0 T (operand!=0), 1 F (operand==0), 2 C (CY), 3 NC (!CY), 4 H (!(Z|CY)), 5 NH (Z|CY), 6 Z, 7 NZ.
- R12: In the cycle that a write is presented, the register-number read still shows the old value. The new value appears after the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| regSel | input | 5 | Register number for the register port |
| regWrEn | input | 1 | Register-port write enable |
| regWrData | input | 16 | Register-port write data |
| regRdData | output | 16 | Register-port read data (combinational) |
| winAddr | input | 5 | Window byte address |
| winWrEn | input | 1 | Window write enable |
| winWrData | input | 8 | Window write data |
| winRdData | output | 8 | Window read data (combinational) |
| condCode | input | 3 | Branch-condition selector |
| condOperand | input | 16 | Operand for the T and F conditions |
| condTrue | output | 1 | Selected condition holds |
| spOddPulse | output | 1 | Odd stack-pointer value was written |
| noneWrErr | output | 1 | Write to an unused register number occurred |

## Verification
Two write paths can land on the same register byte in one cycle: the register-number port and the memory window. The bench provokes this by writing X of the active bank through both ports on one edge. It then reads the byte back through both ports and expects the register-port value. The bench also presses a status-word write and a byte write into back-to-back cycles. It checks in the window that the second write landed in the newly selected bank.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 2 * BYTE_W;
  localparam int NUM_BANKS  = 4;
  localparam int BANK_REGS  = 8;
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int IDX_W      = $clog2(BANK_REGS);
  localparam int WIN_BYTES  = NUM_BANKS * BANK_REGS;
  localparam int WIN_AW     = $clog2(WIN_BYTES);
  localparam int SEL_W      = 5;
  localparam int COND_W     = 3;

  // status word bit positions
  localparam int PSW_CY   = 0;
  localparam int PSW_RBS0 = 3;
  localparam int PSW_RBS1 = 5;
  localparam int PSW_Z    = 6;

  typedef enum logic [3:0] {
    K_NONE, K_BYTE, K_PAIR, K_SP, K_PSW, K_CS, K_ES, K_PMC, K_MEM
  } accKind_e;

  typedef enum logic [COND_W-1:0] {
    C_T = 3'd0, C_F = 3'd1, C_CY = 3'd2, C_NCY = 3'd3,
    C_HI = 3'd4, C_NHI = 3'd5, C_ZR = 3'd6, C_NZR = 3'd7
  } condSel_e;

  typedef struct packed {
    accKind_e         kind;
    logic [IDX_W-1:0] idx;
    logic             wr;
  } ctlStrobe_t;
endpackage

// File: rtl/gprf_ctrl.sv
module gprf_ctrl
  import gprf_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SEL_W-1:0]    regSel,
  input  logic                regWrEn,
  input  logic [BYTE_W-1:0]   psw,
  input  logic [COND_W-1:0]   condCode,
  input  logic [WORD_W-1:0]   condOperand,
  output ctlStrobe_t          ctl,
  output logic                condTrue,
  output logic                noneWrErr
);
  logic [SEL_W-1:0] byteOffs;
  logic [SEL_W-1:0] pairOffs;
  logic             zFlag;
  logic             cyFlag;
  logic             errQ;

  assign byteOffs = regSel - SEL_W'(1);
  assign pairOffs = regSel - SEL_W'(9);

  always_comb begin
    ctl.kind = K_NONE;
    ctl.idx  = '0;
    ctl.wr   = regWrEn;
    case (regSel) inside
      [SEL_W'(1):SEL_W'(8)]: begin
        ctl.kind = K_BYTE;
        ctl.idx  = byteOffs[IDX_W-1:0];
      end
      [SEL_W'(9):SEL_W'(12)]: begin
        ctl.kind = K_PAIR;
        ctl.idx  = IDX_W'(pairOffs[1:0]);
      end
      SEL_W'(13): ctl.kind = K_SP;
      SEL_W'(14): ctl.kind = K_PSW;
      SEL_W'(15): ctl.kind = K_CS;
      SEL_W'(16): ctl.kind = K_ES;
      SEL_W'(17): ctl.kind = K_PMC;
      SEL_W'(18): ctl.kind = K_MEM;
      default:    ctl.kind = K_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= regWrEn && (ctl.kind == K_NONE);
  end
  assign noneWrErr = errQ;

  assign zFlag  = psw[PSW_Z];
  assign cyFlag = psw[PSW_CY];

  always_comb begin
    case (condSel_e'(condCode))
      C_T:     condTrue = (condOperand != '0);
      C_F:     condTrue = (condOperand == '0);
      C_CY:    condTrue = cyFlag;
      C_NCY:   condTrue = !cyFlag;
      C_HI:    condTrue = !(zFlag || cyFlag);
      C_NHI:   condTrue = zFlag || cyFlag;
      C_ZR:    condTrue = zFlag;
      default: condTrue = !zFlag;
    endcase
  end

  AST_ERR_AFTER_BAD_WR: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == '0) |=> noneWrErr); // R8
  AST_NO_ERR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn) |=> !noneWrErr); // R8
endmodule

// File: rtl/gprf_dp.sv
module gprf_dp
  import gprf_pkg::*;
#(
  parameter logic [BYTE_W-1:0] REG_INIT = 8'h11,
  parameter logic [BYTE_W-1:0] PSW_INIT = 8'h06,
  parameter logic [BYTE_W-1:0] CS_INIT  = 8'h00,
  parameter logic [BYTE_W-1:0] ES_INIT  = 8'h0F,
  parameter logic [BYTE_W-1:0] PMC_INIT = 8'h00,
  parameter logic [BYTE_W-1:0] MEM_INIT = 8'h00,
  parameter logic [WORD_W-1:0] SP_INIT  = 16'h0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic [WORD_W-1:0]   wrData,
  input  logic [WIN_AW-1:0]   winAddr,
  input  logic                winWrEn,
  input  logic [BYTE_W-1:0]   winWrData,
  output logic [WORD_W-1:0]   rdData,
  output logic [BYTE_W-1:0]   winRdData,
  output logic [BYTE_W-1:0]   psw,
  output logic                spOdd
);
  logic [BYTE_W-1:0] bankMem [WIN_BYTES];
  logic [BYTE_W-1:0] pswQ, csQ, esQ, pmcQ, memQ;
  logic [WORD_W-1:0] spQ;
  logic              spOddQ;
  logic [BANK_W-1:0] actBank;
  logic [BANK_W-1:0] winBank;
  logic [WIN_AW-1:0] byteAddr, pairLo, pairHi;
  logic              byteWr, pairWr;

  assign actBank  = {pswQ[PSW_RBS1], pswQ[PSW_RBS0]};
  assign winBank  = BANK_W'(NUM_BANKS - 1) - actBank;
  assign byteAddr = {winBank, ctl.idx};
  assign pairLo   = {winBank, ctl.idx[IDX_W-2:0], 1'b0};
  assign pairHi   = {winBank, ctl.idx[IDX_W-2:0], 1'b1};
  assign byteWr   = ctl.wr && (ctl.kind == K_BYTE);
  assign pairWr   = ctl.wr && (ctl.kind == K_PAIR);

  // bank bytes: register port has priority over the window port
  always_ff @(posedge clk) begin
    for (int e = 0; e < WIN_BYTES; e++) begin
      if (!rstN)
        bankMem[e] <= REG_INIT;
      else if (byteWr && byteAddr == WIN_AW'(e))
        bankMem[e] <= wrData[BYTE_W-1:0];
      else if (pairWr && pairLo == WIN_AW'(e))
        bankMem[e] <= wrData[BYTE_W-1:0];
      else if (pairWr && pairHi == WIN_AW'(e))
        bankMem[e] <= wrData[WORD_W-1:BYTE_W];
      else if (winWrEn && winAddr == WIN_AW'(e))
        bankMem[e] <= winWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pswQ   <= PSW_INIT;
      csQ    <= CS_INIT;
      esQ    <= ES_INIT;
      pmcQ   <= PMC_INIT;
      memQ   <= MEM_INIT;
      spQ    <= SP_INIT;
      spOddQ <= 1'b0;
    end else begin
      spOddQ <= ctl.wr && (ctl.kind == K_SP) && wrData[0];
      if (ctl.wr) begin
        case (ctl.kind)
          K_SP:    spQ  <= {wrData[WORD_W-1:1], 1'b0};
          K_PSW:   pswQ <= wrData[BYTE_W-1:0];
          K_CS:    csQ  <= wrData[BYTE_W-1:0];
          K_ES:    esQ  <= wrData[BYTE_W-1:0];
          K_PMC:   pmcQ <= wrData[BYTE_W-1:0];
          K_MEM:   memQ <= wrData[BYTE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (ctl.kind)
      K_BYTE:  rdData = {{BYTE_W{1'b0}}, bankMem[byteAddr]};
      K_PAIR:  rdData = {bankMem[pairHi], bankMem[pairLo]};
      K_SP:    rdData = spQ;
      K_PSW:   rdData = {{BYTE_W{1'b0}}, pswQ};
      K_CS:    rdData = {{BYTE_W{1'b0}}, csQ};
      K_ES:    rdData = {{BYTE_W{1'b0}}, esQ};
      K_PMC:   rdData = {{BYTE_W{1'b0}}, pmcQ};
      K_MEM:   rdData = {{BYTE_W{1'b0}}, memQ};
      default: rdData = '0;
    endcase
  end

  assign winRdData = bankMem[winAddr];
  assign psw       = pswQ;
  assign spOdd     = spOddQ;

  AST_SP_EVEN_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wr && ctl.kind == K_SP) |=> (spQ == {$past(wrData[WORD_W-1:1]), 1'b0})); // R4
  AST_PAIR_HIGH_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    pairWr |=> (bankMem[$past(pairHi)] == $past(wrData[WORD_W-1:BYTE_W]))); // R3
  AST_BANK_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wr && ctl.kind == K_PSW) |=>
      (actBank == {$past(wrData[PSW_RBS1]), $past(wrData[PSW_RBS0])})); // R6
  AST_NONE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wr && ctl.kind == K_NONE) |=> ($stable(pswQ) && $stable(spQ) && $stable(esQ))); // R8
  AST_REG_PORT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (byteWr && winWrEn && winAddr == byteAddr) |=>
      (bankMem[$past(byteAddr)] == $past(wrData[BYTE_W-1:0]))); // R10
endmodule

// File: rtl/banked_gpr_file.sv
module banked_gpr_file
  import gprf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  regSel,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic [4:0]  winAddr,
  input  logic        winWrEn,
  input  logic [7:0]  winWrData,
  output logic [7:0]  winRdData,
  input  logic [2:0]  condCode,
  input  logic [15:0] condOperand,
  output logic        condTrue,
  output logic        spOddPulse,
  output logic        noneWrErr
);
  ctlStrobe_t        ctl;
  logic [BYTE_W-1:0] psw;

  gprf_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regSel     (regSel),
    .regWrEn    (regWrEn),
    .psw        (psw),
    .condCode   (condCode),
    .condOperand(condOperand),
    .ctl        (ctl),
    .condTrue   (condTrue),
    .noneWrErr  (noneWrErr)
  );

  gprf_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrData   (regWrData),
    .winAddr  (winAddr),
    .winWrEn  (winWrEn),
    .winWrData(winWrData),
    .rdData   (regRdData),
    .winRdData(winRdData),
    .psw      (psw),
    .spOdd    (spOddPulse)
  );
endmodule

// File: tb/sim_banked_gpr_file.sv
`timescale 1ns/1ps
module sim_banked_gpr_file;
  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  regSel;
  logic        regWrEn;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic [4:0]  winAddr;
  logic        winWrEn;
  logic [7:0]  winWrData;
  logic [7:0]  winRdData;
  logic [2:0]  condCode;
  logic [15:0] condOperand;
  logic        condTrue;
  logic        spOddPulse;
  logic        noneWrErr;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  int          srcQ[$];
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  banked_gpr_file u0 (.*);

  // monitor: pops expected items and compares against the selected output
  initial begin
    int s; logic [15:0] e; logic [15:0] a; string t;
    forever begin
      wait (srcQ.size() > 0);
      s = srcQ.pop_front(); e = expQ.pop_front(); t = tagQ.pop_front();
      case (s)
        0:       a = regRdData;
        1:       a = {8'h00, winRdData};
        2:       a = {15'd0, condTrue};
        3:       a = {15'd0, spOddPulse};
        default: a = {15'd0, noneWrErr};
      endcase
      nChecks++;
      if (a !== e) begin
        nFail++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic expectNow(int src, logic [15:0] exp, string tag);
    srcQ.push_back(src); expQ.push_back(exp); tagQ.push_back(tag);
    #1;
  endtask

  task automatic drive(logic [4:0] sel, logic wr, logic [15:0] data,
                       logic [4:0] wa, logic wwr, logic [7:0] wd);
    @(negedge clk);
    regSel = sel; regWrEn = wr; regWrData = data;
    winAddr = wa; winWrEn = wwr; winWrData = wd;
  endtask

  task automatic regWr(logic [4:0] sel, logic [15:0] data);
    drive(sel, 1'b1, data, 5'd0, 1'b0, 8'h00);
  endtask

  task automatic readReg(logic [4:0] sel, logic [15:0] exp, string tag);
    drive(sel, 1'b0, 16'h0, 5'd0, 1'b0, 8'h00); #1;
    expectNow(0, exp, tag);
  endtask

  task automatic readWin(logic [4:0] wa, logic [7:0] exp, string tag);
    drive(5'd0, 1'b0, 16'h0, wa, 1'b0, 8'h00); #1;
    expectNow(1, {8'h00, exp}, tag);
  endtask

  task automatic checkFlag(int src, logic exp, string tag);
    drive(5'd0, 1'b0, 16'h0, 5'd0, 1'b0, 8'h00); #1;
    expectNow(src, {15'd0, exp}, tag);
  endtask

  task automatic checkCond(logic [2:0] code, logic [15:0] opnd, logic exp, string tag);
    drive(5'd0, 1'b0, 16'h0, 5'd0, 1'b0, 8'h00);
    condCode = code; condOperand = opnd; #1;
    expectNow(2, {15'd0, exp}, tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regSel = '0; regWrEn = 1'b0; regWrData = '0;
    winAddr = '0; winWrEn = 1'b0; winWrData = '0;
    condCode = '0; condOperand = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(5'd1,  16'h0011, "R1 X reset");
    readReg(5'd9,  16'h1111, "R1 AX reset");
    readReg(5'd14, 16'h0006, "R1 PSW reset");
    readReg(5'd16, 16'h000F, "R1 ES reset");
    readReg(5'd15, 16'h0000, "R1 CS reset");
    readReg(5'd17, 16'h0000, "R1 PMC reset");
    readReg(5'd18, 16'h0000, "R1 MEM reset");
    readReg(5'd13, 16'h0000, "R1 SP reset");
    readWin(5'd0,  8'h11, "R1 window low reset");
    readWin(5'd31, 8'h11, "R1 window high reset");
    checkFlag(3, 1'b0, "R1 spOdd reset");
    checkFlag(4, 1'b0, "R1 err reset");

    // R12 old value visible before the edge
    regWr(5'd1, 16'h0021); #1;
    expectNow(0, 16'h0011, "R12 read before edge");
    // R2 byte writes in bank 0
    for (int c = 2; c <= 8; c++) regWr(5'(c), 16'(8'h20 + c));
    for (int c = 1; c <= 8; c++) readReg(5'(c), 16'(8'h20 + c), "R2 byte readback");
    readWin(5'd24, 8'h21, "R7 bank0 X in window");
    readWin(5'd31, 8'h28, "R7 bank0 H in window");
    // R3 pair reads
    readReg(5'd9,  16'h2221, "R3 AX read");
    readReg(5'd10, 16'h2423, "R3 BC read");
    readReg(5'd11, 16'h2625, "R3 DE read");
    readReg(5'd12, 16'h2827, "R3 HL read");
    // R2 high data byte ignored on byte write
    regWr(5'd2, 16'hAB55);
    readReg(5'd2, 16'h0055, "R2 low byte stored");
    readReg(5'd9, 16'h5521, "R3 AX after A write");
    // R3 pair write split
    regWr(5'd11, 16'hBEEF);
    readReg(5'd6, 16'h00BE, "R3 D high byte");
    readReg(5'd5, 16'h00EF, "R3 E low byte");
    readWin(5'd28, 8'hEF, "R7 E window");
    readWin(5'd29, 8'hBE, "R7 D window");

    // R6 bank switch takes effect next cycle
    regWr(5'd14, 16'h0008);
    regWr(5'd1,  16'h0099);
    readReg(5'd14, 16'h0008, "R6 PSW readback");
    readReg(5'd1,  16'h0099, "R6 bank1 X");
    readWin(5'd16, 8'h99, "R6 bank1 X at window 16");
    readWin(5'd24, 8'h21, "R6 bank0 X untouched");
    regWr(5'd14, 16'h0020);
    readReg(5'd1, 16'h0011, "R6 bank2 fresh X");
    regWr(5'd4, 16'h0044);
    readWin(5'd11, 8'h44, "R7 bank2 B at window 11");
    regWr(5'd14, 16'h0028);
    regWr(5'd12, 16'h1357);
    readWin(5'd7, 8'h13, "R7 bank3 H at window 7");
    readWin(5'd6, 8'h57, "R7 bank3 L at window 6");
    // R7 window write into an inactive bank
    drive(5'd0, 1'b0, 16'h0, 5'd17, 1'b1, 8'h5A);
    readWin(5'd17, 8'h5A, "R7 window write readback");
    regWr(5'd14, 16'h0008);
    readReg(5'd2, 16'h005A, "R7 window write seen via bank1 A");

    // R10 both ports write bank1 X in one cycle
    drive(5'd1, 1'b1, 16'h00C3, 5'd16, 1'b1, 8'h3C);
    readReg(5'd1, 16'h00C3, "R10 register port wins");
    readWin(5'd16, 8'hC3, "R10 window shows winner");

    // R4 R5 stack pointer
    regWr(5'd13, 16'h1235);
    checkFlag(3, 1'b1, "R5 odd pulse high");
    checkFlag(3, 1'b0, "R5 odd pulse one cycle");
    readReg(5'd13, 16'h1234, "R4 SP bit0 cleared");
    regWr(5'd13, 16'h2000);
    checkFlag(3, 1'b0, "R5 no pulse on even");
    readReg(5'd13, 16'h2000, "R4 SP even value");

    // R8 unused register numbers
    regWr(5'd0, 16'hFFFF);
    checkFlag(4, 1'b1, "R8 error pulse");
    checkFlag(4, 1'b0, "R8 error one cycle");
    readReg(5'd0, 16'h0000, "R8 none reads zero");
    readReg(5'd14, 16'h0008, "R8 PSW unchanged");
    readReg(5'd2, 16'h005A, "R8 A unchanged");
    readReg(5'd13, 16'h2000, "R8 SP unchanged");
    regWr(5'd25, 16'h1234);
    checkFlag(4, 1'b1, "R8 error on code 25");
    readReg(5'd25, 16'h0000, "R8 code 25 reads zero");

    // R9 status bytes
    regWr(5'd15, 16'h1234);
    regWr(5'd16, 16'h0007);
    regWr(5'd17, 16'hFF01);
    regWr(5'd18, 16'h00A5);
    readReg(5'd15, 16'h0034, "R9 CS low byte");
    readReg(5'd16, 16'h0007, "R9 ES");
    readReg(5'd17, 16'h0001, "R9 PMC");
    readReg(5'd18, 16'h00A5, "R9 MEM");

    // R11 condition evaluator
    regWr(5'd14, 16'h0000);
    checkCond(3'd0, 16'h0000, 1'b0, "R11 T zero");
    checkCond(3'd0, 16'h0100, 1'b1, "R11 T nonzero");
    checkCond(3'd1, 16'h0000, 1'b1, "R11 F zero");
    checkCond(3'd1, 16'h0005, 1'b0, "R11 F nonzero");
    checkCond(3'd2, 16'h0000, 1'b0, "R11 C clear");
    checkCond(3'd3, 16'h0000, 1'b1, "R11 NC clear");
    checkCond(3'd4, 16'h0000, 1'b1, "R11 H clear");
    checkCond(3'd5, 16'h0000, 1'b0, "R11 NH clear");
    checkCond(3'd6, 16'h0000, 1'b0, "R11 Z clear");
    checkCond(3'd7, 16'h0000, 1'b1, "R11 NZ clear");
    regWr(5'd14, 16'h0001);
    checkCond(3'd2, 16'h0000, 1'b1, "R11 C set");
    checkCond(3'd3, 16'h0000, 1'b0, "R11 NC set");
    checkCond(3'd4, 16'h0000, 1'b0, "R11 H with CY");
    checkCond(3'd5, 16'h0000, 1'b1, "R11 NH with CY");
    regWr(5'd14, 16'h0040);
    checkCond(3'd6, 16'h0000, 1'b1, "R11 Z set");
    checkCond(3'd7, 16'h0000, 1'b0, "R11 NZ set");
    checkCond(3'd4, 16'h0000, 1'b0, "R11 H with Z");
    checkCond(3'd5, 16'h0000, 1'b1, "R11 NH with Z");

    wait (srcQ.size() == 0);
    #2;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule